// File: doc/BRIEF.md
# Peripheral DMA Channel Sequencer

This block is the control core of a single DMA channel that moves 32-bit words between a peripheral and memory. Software programs a control word that selects the direction, the mode, the word count and one of several peripheral request lines. The block then paces the transfer one word at a time. Each word is handed off through a simple request/acknowledge pair to a separate address and bus engine. A status word reports whether the channel is busy, whether an end-of-count event is pending, which half of a double buffer is current, and how many words remain in the current pass.

There are two modes. In one-shot mode the channel moves the programmed number of words, flags the end of count and stops by itself. In continuous mode the programmed count describes half of a ring buffer. The channel flags each completed half, flips its half indicator, reloads the count and keeps running. Transfers only happen while a chip-level enable input is high. When flow control is on, each word waits for the selected peripheral request line. A reserved select code parks the channel without clearing its enable, so software can freeze the channel and read a stable count.

Top module: `dmach_channel`

## Requirements
- R1: After reset the control readback, the status readback, `irq` and `word_req` are all zero.
- R2: The control word has these fields: bit 31 enable, bit 30 interrupt enable, bit 28 direction (0 = peripheral to memory), bit 27 one-shot, bit 21 flow control, bits 20:16 request select and bits 15:2 word count minus one. All other bits read back as zero. `word_dir` follows bit 28.
- R3: A control write that sets bit 31 while bit 31 is clear starts the channel. The busy flag sets, the counter loads from bits 15:2 of the written value and the half flag clears. A control write with bit 31 clear drops busy.
- R4: With flow control off, a word moves in every cycle that `word_ack` is high. With flow control on, a word moves only in cycles where the selected request line is high. No word moves while `glb_en` is low, and none moves on a request line that is not selected.
- R5: Select code 31, or any code at or above the number of request lines, stalls a flow-controlled channel. Enable and busy stay set. Writing a valid code with enable still set resumes the transfer without reloading the count.
- R6: Status bits 15:2 show the remaining word count minus one. The value falls by one with each word moved that is not the last of a pass.
- R7: In one-shot mode the channel moves count+1 words, then sets the pending flag. Busy reads zero in the cycle after the last word, and control bit 31 clears.
- R8: In continuous mode each pass moves count+1 words. At the end of each pass the pending flag sets, the half flag (status bit 28) toggles, the counter reloads from the control word and busy stays set.
- R9: Status bit 31 is busy and bit 30 is pending. A status write with bit 30 set clears pending, and a status write with bit 30 clear leaves it alone. When an end of pass and a clear fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when pending is set and control bit 30 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Chip-level DMA enable; gates all word moves |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| sta_we | input | 1 | Status word write strobe |
| sta_wdata | input | 32 | Status write data; bit 30 clears pending |
| periph_req | input | NUM_REQ | Peripheral request lines |
| word_ack | input | 1 | Bus engine accepts the current word |
| cfg_rdata | output | 32 | Control word readback |
| sta_rdata | output | 32 | Status word readback |
| word_req | output | 1 | A word is ready to move this cycle |
| word_dir | output | 1 | Direction for the bus engine |
| word_half | output | 1 | Current buffer half, for address generation |
| irq | output | 1 | End-of-count interrupt |

## Verification
The hardest case to reach from the ports is an end of pass that lands in the same cycle as a status write clearing the pending flag. The other hard case is the stall on a reserved select code while enable stays set. For the first, the stimulus holds `glb_en` low so that the continuous channel freezes at a known count. It then releases `glb_en` for exactly the number of cycles left in the pass while holding a clearing status write. For the stall, every request line is driven high while the select code is 31, so any word that moved would show up in the count. A live select code is then written over the running channel to show that it resumes with the count left as it was.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  // control word field positions (software decodes these)
  localparam int CW_EN      = 31;
  localparam int CW_IE      = 30;
  localparam int CW_DIR     = 28;
  localparam int CW_ONCE    = 27;
  localparam int CW_FLOW    = 21;
  localparam int CW_SEL_LSB = 16;
  localparam int SEL_W      = 5;
  localparam int CW_CNT_LSB = 2;
  localparam int CNT_MAX_W  = 14;

  // status word field positions
  localparam int ST_BUSY = 31;
  localparam int ST_PEND = 30;
  localparam int ST_HALF = 28;

  localparam logic [SEL_W-1:0] SEL_PARKED = 5'd31;

  typedef struct packed {
    logic             en;
    logic             ie;
    logic             dir;
    logic             once;
    logic             flow;
    logic [SEL_W-1:0] sel;
  } cfg_flags_t;
endpackage

// File: rtl/dmach_cfg_reg.sv
module dmach_cfg_reg
  import dmach_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             auto_off,
  output logic [31:0]      cfg_word,
  output cfg_flags_t       flags,
  output logic [CNT_W-1:0] cnt_field,
  output logic [CNT_W-1:0] wr_cnt_field,
  output logic             start_pulse,
  output logic             stop_pulse
);
  localparam logic [31:0] CNT_MASK = ((32'd1 << CNT_W) - 32'd1) << CW_CNT_LSB;
  localparam logic [31:0] SEL_MASK = ((32'd1 << SEL_W) - 32'd1) << CW_SEL_LSB;
  localparam logic [31:0] BIT_MASK = (32'd1 << CW_EN) | (32'd1 << CW_IE) |
                                     (32'd1 << CW_DIR) | (32'd1 << CW_ONCE) |
                                     (32'd1 << CW_FLOW);
  localparam logic [31:0] WR_MASK  = CNT_MASK | SEL_MASK | BIT_MASK;

  logic [31:0] cfg_q, cfg_d;
  logic        cfg_ld;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_ld = 1'b0;
    if (wr_en) begin
      cfg_d  = wr_data & WR_MASK;
      cfg_ld = 1'b1;
    end else if (auto_off) begin
      cfg_d[CW_EN] = 1'b0;
      cfg_ld       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ld) cfg_q <= cfg_d;
  end

  assign cfg_word     = cfg_q;
  assign flags.en     = cfg_q[CW_EN];
  assign flags.ie     = cfg_q[CW_IE];
  assign flags.dir    = cfg_q[CW_DIR];
  assign flags.once   = cfg_q[CW_ONCE];
  assign flags.flow   = cfg_q[CW_FLOW];
  assign flags.sel    = cfg_q[CW_SEL_LSB +: SEL_W];
  assign cnt_field    = cfg_q[CW_CNT_LSB +: CNT_W];
  assign wr_cnt_field = wr_data[CW_CNT_LSB +: CNT_W];
  assign start_pulse  = wr_en & wr_data[CW_EN] & ~cfg_q[CW_EN];
  assign stop_pulse   = wr_en & ~wr_data[CW_EN];

  AST_AUTO_OFF_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    auto_off && !wr_en |=> !cfg_q[CW_EN]); // R7
endmodule

// File: rtl/dmach_req_mux.sv
module dmach_req_mux
  import dmach_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] periph_req,
  input  logic [SEL_W-1:0]   sel,
  input  logic               flow,
  output logic               grant
);
  localparam int LINES_OK = (NUM_REQ >= 1 && NUM_REQ < 31) ? 1 : 0;

  logic [NUM_REQ-1:0] hit;

  generate
    if (LINES_OK == 1) begin : g_lines
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_hit
        assign hit[i] = periph_req[i] & (sel == SEL_W'(i));
      end
    end else begin : g_bad
      assign hit = '0;
    end
  endgenerate

  assign grant = flow ? (|hit) : 1'b1;

  AST_PARKED_SEL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    flow && sel == SEL_PARKED |-> !grant); // R5
endmodule

// File: rtl/dmach_word_ctr.sv
module dmach_word_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             once,
  input  logic             xfer,
  input  logic             pend_clr,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             half,
  output logic             pend,
  output logic             once_done
);
  logic             busy_d, half_d, pend_d;
  logic [CNT_W-1:0] cnt_d;
  logic             last, pass_done, step;

  assign last      = (cnt == '0);
  assign step      = busy & xfer;
  assign pass_done = step & last;
  assign once_done = pass_done & once;

  always_comb begin
    busy_d = busy;
    if (start)          busy_d = 1'b1;
    else if (stop)      busy_d = 1'b0;
    else if (once_done) busy_d = 1'b0;

    cnt_d = cnt;
    if (start)     cnt_d = load_val;
    else if (step) cnt_d = last ? reload_val : cnt - 1'b1;

    half_d = half;
    if (start)                  half_d = 1'b0;
    else if (pass_done && !once) half_d = ~half;

    pend_d = pend;
    if (pass_done)     pend_d = 1'b1;
    else if (pend_clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      half <= 1'b0;
      pend <= 1'b0;
    end else begin
      busy <= busy_d;
      cnt  <= cnt_d;
      half <= half_d;
      pend <= pend_d;
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && cnt == $past(load_val) && !half); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer && !last && !start |=> cnt == $past(cnt) - 1'b1); // R6
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer && last && once && !start |=> !busy && pend); // R7
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer && last && !once && !start && !stop |=> busy && half != $past(half)); // R8
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr && !(busy && xfer && last) |=> !pend); // R9
endmodule

// File: rtl/dmach_channel.sv
module dmach_channel
  import dmach_pkg::*;
#(
  parameter int NUM_REQ = 16,
  parameter int CNT_W   = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  input  logic               sta_we,
  input  logic [31:0]        sta_wdata,
  input  logic [NUM_REQ-1:0] periph_req,
  input  logic               word_ack,
  output logic [31:0]        cfg_rdata,
  output logic [31:0]        sta_rdata,
  output logic               word_req,
  output logic               word_dir,
  output logic               word_half,
  output logic               irq
);
  cfg_flags_t       flags;
  logic [CNT_W-1:0] cnt_field, wr_cnt_field, cnt;
  logic             start_pulse, stop_pulse, once_done;
  logic             grant, busy, half, pend, xfer, pend_clr;
  logic             unused_sta;

  assign unused_sta = ^{sta_wdata[31], sta_wdata[29:0]};
  assign pend_clr   = sta_we & sta_wdata[ST_PEND];

  dmach_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .auto_off(once_done), .cfg_word(cfg_rdata), .flags(flags),
    .cnt_field(cnt_field), .wr_cnt_field(wr_cnt_field),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse)
  );

  dmach_req_mux #(.NUM_REQ(NUM_REQ)) u_req (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .sel(flags.sel),
    .flow(flags.flow), .grant(grant)
  );

  dmach_word_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .stop(stop_pulse),
    .load_val(wr_cnt_field), .reload_val(cnt_field), .once(flags.once),
    .xfer(xfer), .pend_clr(pend_clr), .busy(busy), .cnt(cnt),
    .half(half), .pend(pend), .once_done(once_done)
  );

  assign word_req  = busy & glb_en & grant;
  assign xfer      = word_req & word_ack;
  assign word_dir  = flags.dir;
  assign word_half = half;
  assign irq       = pend & flags.ie;

  always_comb begin
    sta_rdata                        = '0;
    sta_rdata[ST_BUSY]               = busy;
    sta_rdata[ST_PEND]               = pend;
    sta_rdata[ST_HALF]               = half;
    sta_rdata[CW_CNT_LSB +: CNT_W]   = cnt;
  end

  AST_MOVE_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |-> glb_en && sta_rdata[ST_BUSY]); // R4
  AST_IRQ_ONLY_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_rdata[CW_IE] && sta_rdata[ST_PEND]); // R10
endmodule

// File: tb/tb_dmach_channel.sv
module tb_dmach_channel;
  localparam int NREQ = 16;

  logic            clk, rst_n, glb_en, cfg_we, sta_we, word_ack, wc_clr;
  logic [31:0]     cfg_wdata, sta_wdata, cfg_rdata, sta_rdata;
  logic [NREQ-1:0] periph_req;
  logic            word_req, word_dir, word_half, irq;
  int              n_chk, n_fail, nwords;

  dmach_channel #(.NUM_REQ(NREQ), .CNT_W(14)) dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .sta_we(sta_we), .sta_wdata(sta_wdata),
    .periph_req(periph_req), .word_ack(word_ack), .cfg_rdata(cfg_rdata),
    .sta_rdata(sta_rdata), .word_req(word_req), .word_dir(word_dir),
    .word_half(word_half), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     nwords <= 0;
    else if (wc_clr)                nwords <= 0;
    else if (word_req && word_ack)  nwords <= nwords + 1;
  end

  function automatic logic [31:0] mk(input bit en, ie, dir, once, flow,
                                     input int sel, input int cnt);
    logic [31:0] w;
    w = '0;
    w[31] = en; w[30] = ie; w[28] = dir; w[27] = once; w[21] = flow;
    w[20:16] = sel[4:0]; w[15:2] = cnt[13:0];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_sta(input logic [31:0] v);
    @(negedge clk); sta_we = 1'b1; sta_wdata = v;
    @(negedge clk); sta_we = 1'b0;
  endtask

  task automatic clr_words();
    @(negedge clk); wc_clr = 1'b1;
    @(negedge clk); wc_clr = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && sta_rdata[31]; i++) @(negedge clk);
  endtask

  // {count[13:0], flow, sel[4:0], dir}
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {14'd0,  1'b0, 5'd0,  1'b0},
    {14'd3,  1'b0, 5'd0,  1'b1},
    {14'd7,  1'b1, 5'd2,  1'b0},
    {14'd12, 1'b1, 5'd15, 1'b1},
    {14'd1,  1'b1, 5'd9,  1'b0},
    {14'd20, 1'b0, 5'd4,  1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; glb_en = 1'b0; cfg_we = 1'b0; sta_we = 1'b0;
    cfg_wdata = '0; sta_wdata = '0; periph_req = '0; word_ack = 1'b1; wc_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cfg", cfg_rdata, 32'h0);
    chk("R1 sta", sta_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 word_req", {31'b0, word_req}, 32'h0);

    // R2 field readback, reserved bits zero, no start without enable
    wr_cfg(32'h7FFF_FFFF);
    chk("R2 readback", cfg_rdata, 32'h583F_FFFC);
    chk("R2 dir", {31'b0, word_dir}, 32'h1);
    chk("R3 no start", {31'b0, sta_rdata[31]}, 32'h0);
    wr_cfg(32'h0);

    // table-driven one-shot runs
    glb_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      int c, s; bit f, d;
      c = int'(VEC[v][20:7]); f = VEC[v][6]; s = int'(VEC[v][5:1]); d = VEC[v][0];
      clr_words();
      periph_req = f ? (NREQ'(1) << s) : '0;
      wr_cfg(mk(1, 1, d, 1, f, s, c));
      chk("R3 busy after start", {31'b0, sta_rdata[31]}, 32'h1);
      chk("R2 word_dir", {31'b0, word_dir}, {31'b0, d});
      wait_idle(400);
      chk("R7 word total", nwords, c + 1);
      chk("R7 pending", {31'b0, sta_rdata[30]}, 32'h1);
      chk("R7 enable cleared", {31'b0, cfg_rdata[31]}, 32'h0);
      chk("R10 irq on", {31'b0, irq}, 32'h1);
      periph_req = '0;
      wr_sta(32'h4000_0000);
      chk("R9 cleared", {31'b0, sta_rdata[30]}, 32'h0);
    end

    // R7 busy drop timing, R10 masked irq, R9 writes
    clr_words();
    wr_cfg(mk(1, 0, 0, 1, 1, 4, 0));
    chk("R4 no req no move", {31'b0, word_req}, 32'h0);
    chk("R7 busy before word", {31'b0, sta_rdata[31]}, 32'h1);
    periph_req[4] = 1'b1;
    @(negedge clk);
    periph_req = '0;
    chk("R7 busy dropped next cycle", {31'b0, sta_rdata[31]}, 32'h0);
    chk("R7 one word", nwords, 1);
    chk("R10 masked irq", {31'b0, irq}, 32'h0);
    wr_sta(32'hBFFF_FFFF);
    chk("R9 bit30 clear keeps pend", {31'b0, sta_rdata[30]}, 32'h1);
    wr_sta(32'h4000_0000);
    chk("R9 clear", {31'b0, sta_rdata[30]}, 32'h0);

    // R6 remaining count, R4 unselected line, R3 stop
    clr_words();
    wr_cfg(mk(1, 0, 0, 1, 1, 1, 5));
    chk("R6 initial count", {18'b0, sta_rdata[15:2]}, 32'd5);
    periph_req[1] = 1'b1;
    repeat (2) @(negedge clk);
    periph_req = '0;
    chk("R6 after two", {18'b0, sta_rdata[15:2]}, 32'd3);
    periph_req[2] = 1'b1;
    repeat (3) @(negedge clk);
    periph_req = '0;
    chk("R4 unselected line", {18'b0, sta_rdata[15:2]}, 32'd3);
    wr_cfg(mk(0, 0, 0, 1, 1, 1, 5));
    chk("R3 stop", {31'b0, sta_rdata[31]}, 32'h0);

    // R5 parked select
    clr_words();
    periph_req = '1;
    wr_cfg(mk(1, 0, 0, 1, 1, 31, 2));
    repeat (5) @(negedge clk);
    chk("R5 no words", nwords, 0);
    chk("R5 enable kept", {31'b0, cfg_rdata[31]}, 32'h1);
    chk("R5 busy kept", {31'b0, sta_rdata[31]}, 32'h1);
    wr_cfg(mk(1, 0, 0, 1, 1, 6, 9));
    wait_idle(50);
    chk("R5 resumed without reload", nwords, 3);
    periph_req = '0;
    wr_sta(32'h4000_0000);

    // R4 global enable gating
    clr_words();
    glb_en = 1'b0;
    wr_cfg(mk(1, 0, 0, 1, 0, 0, 2));
    repeat (4) @(negedge clk);
    chk("R4 glb_en low", nwords, 0);
    glb_en = 1'b1;
    wait_idle(50);
    chk("R4 glb_en high", nwords, 3);
    wr_sta(32'h4000_0000);

    // R8 continuous halves
    clr_words();
    glb_en = 1'b0;
    wr_cfg(mk(1, 1, 0, 0, 0, 0, 1));
    glb_en = 1'b1;
    repeat (2) @(negedge clk);
    glb_en = 1'b0;
    chk("R8 half flag", {31'b0, sta_rdata[28]}, 32'h1);
    chk("R8 word_half", {31'b0, word_half}, 32'h1);
    chk("R8 pending", {31'b0, sta_rdata[30]}, 32'h1);
    chk("R8 still busy", {31'b0, sta_rdata[31]}, 32'h1);
    chk("R8 reload", {18'b0, sta_rdata[15:2]}, 32'd1);
    chk("R10 irq", {31'b0, irq}, 32'h1);
    wr_sta(32'h4000_0000);
    sta_we = 1'b1; sta_wdata = 32'h4000_0000;
    glb_en = 1'b1;
    repeat (2) @(negedge clk);
    glb_en = 1'b0; sta_we = 1'b0;
    chk("R9 set wins over clear", {31'b0, sta_rdata[30]}, 32'h1);
    chk("R8 half back", {31'b0, sta_rdata[28]}, 32'h0);
    chk("R8 words", nwords, 4);
    wr_cfg(32'h0);
    chk("R3 stop continuous", {31'b0, sta_rdata[31]}, 32'h0);

    summary();
  end
endmodule